// File: doc/BRIEF.md
# Single-Byte SMBus Master Sequencer

This block is a master-only two-wire bus controller that moves exactly one byte per request. A host hands it a 7-bit target address, a direction bit and, for writes, one data byte. The block generates a START, sends the address byte and either sends the data byte or receives one byte, and then closes with a STOP. The bus is open-drain: the block pulls SCL or SDA low by raising an output-enable and reads both lines back through a two-flop synchroniser.

A NACK from the target is never reported to the host. The sequencer issues a repeated START and replays the transfer from the address phase until it succeeds. Losing arbitration or finding SDA held low at START aborts the transfer silently. An independent watchdog also aborts the transfer if SCL stays low for the configured timeout. In every abort case busy drops with no done pulse.

The request side is a valid/ready handshake. `req_ready` is high exactly while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and not yet taken, the host keeps it high and holds the request fields stable. While the block is busy, `req_valid` is ignored. The completion side has no back-pressure: `done` is a single-cycle pulse, and `rx_data` holds the last byte read until the next read completes.

Top module: `smb_byte_master`

## Requirements
- R1: A request is accepted only on a cycle where busy is low (`req_ready` = 1). Busy is high in the cycle after acceptance and stays high until the transfer completes or aborts.
- R2: After START, the first byte on SDA is the 7-bit address followed by the direction bit (0 = write, 1 = read), most significant bit first.
- R3: In a write, an ACKed address is followed by the single data byte, MSB first. An ACK of that byte ends the transfer with exactly one STOP.
- R4: In a read, an ACKed address is followed by eight received bits, MSB first. The master answers them with a NACK (SDA released), places the byte on `rx_data` and ends with exactly one STOP.
- R5: A NACK on the address byte, in either direction, causes a repeated START and a full retry from the address phase. The number of STARTs seen equals one plus the number of address NACKs.
- R6: A NACK on the write data byte causes a repeated START and a retry from the address phase, with no STOP in between.
- R7: If the master releases SDA for a 1 bit but reads SDA low, it aborts. Both lines are released, busy drops, no done pulse is given and no retry is made.
- R8: If SDA reads low when the master is about to create START, the transfer aborts in the same way as R7.
- R9: If SCL stays low for `(CLK_HZ/1e6)*TIMEOUT_US` clock cycles while the block is busy, busy drops within a few cycles after that count, with no done pulse.
- R10: On successful completion, `done` is high for exactly one cycle, in the same cycle busy falls. An abort produces no done pulse.
- R11: A `req_valid` pulse with different fields while busy has no effect on the transfer in progress.
- R12: After any abort, the next read completes normally and still answers its data byte with a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host offers a transfer request |
| req_ready | output | 1 | Block can take a request (idle) |
| req_addr | input | 7 | Target address |
| req_rd | input | 1 | 1 = read one byte, 0 = write one byte |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| rx_data | output | 8 | Last byte read |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A wrong bit counter or shift register shows up as a misframed address byte at the target model within the first nine SCL periods. A wrong retry decision appears as a START count or STOP count that does not match the number of NACKs injected, or as a hung busy. A stale ACK-enable state would show as an ACK instead of the expected NACK after a read's data byte. A wrong watchdog count moves the moment busy drops away from the timeout window measured from the first cycle SCL is held low.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BYTE,
    ST_ACK,
    ST_STOP
  } eng_state_e;

  typedef enum logic {
    STG_ADDR,
    STG_DATA
  } stage_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/smb_qtick.sv
module smb_qtick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/smb_low_watch.sv
module smb_low_watch #(
  parameter int LIMIT = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (scl_lvl) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      fire <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      fire <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_seq_fsm.sv
module smb_seq_fsm
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [6:0] req_addr,
  input  logic       req_rd,
  input  logic [7:0] req_wdata,
  output logic       req_ready,
  input  logic       tick,
  input  logic       wd_fire,
  input  logic       sda_lvl,
  output logic       tick_clr,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       scl_oe,
  output logic       sda_oe
);
  eng_state_e state;
  stage_e     stage;
  logic [1:0] ph;
  logic [2:0] bitcnt;
  logic [7:0] shreg, wdata_q, rx_q;
  logic [6:0] addr_q;
  logic       rw_q, ack_en, ack_seen, busy_q, done_q, scl_q, sda_q;
  logic       rxmode, accept, bus_bad, arb_lost, abort_c;

  always_comb begin
    rxmode   = (stage == STG_DATA) && rw_q;
    accept   = req_valid && !busy_q;
    bus_bad  = tick && (state == ST_START) && (ph == 2'd2) && !sda_lvl;
    arb_lost = tick && (state == ST_BYTE) && !rxmode && (ph == 2'd2)
               && shreg[7] && !sda_lvl;
    abort_c  = bus_bad || arb_lost || (wd_fire && (state != ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stage    <= STG_ADDR;
      ph       <= '0;
      bitcnt   <= '0;
      shreg    <= '0;
      wdata_q  <= '0;
      rx_q     <= '0;
      addr_q   <= '0;
      rw_q     <= 1'b0;
      ack_en   <= 1'b1;
      ack_seen <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_c) begin
        state  <= ST_IDLE;
        busy_q <= 1'b0;
        scl_q  <= 1'b0;
        sda_q  <= 1'b0;
        ack_en <= 1'b1;
        ph     <= '0;
      end else if (state == ST_IDLE) begin
        if (accept) begin
          addr_q  <= req_addr;
          rw_q    <= req_rd;
          wdata_q <= req_wdata;
          busy_q  <= 1'b1;
          state   <= ST_START;
          ph      <= '0;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (state)
          ST_START: begin
            case (ph)
              2'd0: sda_q <= 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b1;
              default: begin
                scl_q  <= 1'b1;
                shreg  <= {addr_q, rw_q};
                stage  <= STG_ADDR;
                bitcnt <= 3'd7;
                state  <= ST_BYTE;
              end
            endcase
          end
          ST_BYTE: begin
            case (ph)
              2'd0: sda_q <= rxmode ? 1'b0 : ~shreg[7];
              2'd1: scl_q <= 1'b0;
              2'd2: if (rxmode) shreg <= {shreg[6:0], sda_lvl};
              default: begin
                scl_q <= 1'b1;
                if (!rxmode) shreg <= {shreg[6:0], 1'b0};
                if (bitcnt == 3'd0) state <= ST_ACK;
                else                bitcnt <= bitcnt - 3'd1;
              end
            endcase
          end
          ST_ACK: begin
            case (ph)
              2'd0: sda_q <= rxmode ? ack_en : 1'b0;
              2'd1: scl_q <= 1'b0;
              2'd2: if (!rxmode) ack_seen <= !sda_lvl;
              default: begin
                scl_q <= 1'b1;
                if (stage == STG_ADDR) begin
                  if (!ack_seen) begin
                    state <= ST_START;
                  end else begin
                    stage  <= STG_DATA;
                    bitcnt <= 3'd7;
                    state  <= ST_BYTE;
                    if (rw_q) ack_en <= 1'b0;
                    else      shreg  <= wdata_q;
                  end
                end else if (rw_q) begin
                  rx_q   <= shreg;
                  ack_en <= 1'b1;
                  state  <= ST_STOP;
                end else begin
                  state <= ack_seen ? ST_STOP : ST_START;
                end
              end
            endcase
          end
          ST_STOP: begin
            case (ph)
              2'd0: sda_q <= 1'b1;
              2'd1: scl_q <= 1'b0;
              2'd2: sda_q <= 1'b0;
              default: begin
                state  <= ST_IDLE;
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            endcase
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign req_ready = !busy_q;
  assign tick_clr  = (state == ST_IDLE);
  assign busy      = busy_q;
  assign done      = done_q;
  assign rx_data   = rx_q;
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
endmodule

// File: rtl/smb_byte_master.sv
module smb_byte_master #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int SCL_HZ     = 100_000,
  parameter int TIMEOUT_US = 25_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [6:0] req_addr,
  input  logic       req_rd,
  input  logic [7:0] req_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       scl_in,
  input  logic       sda_in
);
  localparam int QDIV   = CLK_HZ / (SCL_HZ * 4);
  localparam int WD_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;

  logic [1:0] lines_sync;
  logic       tick, tick_clr, wd_fire;

  smb_sync #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    (lines_sync)
  );

  smb_qtick #(.QDIV(QDIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tick_clr),
    .tick (tick)
  );

  smb_low_watch #(.LIMIT(WD_CYC)) u_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_lvl(lines_sync[1]),
    .fire   (wd_fire)
  );

  smb_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_rd   (req_rd),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .tick     (tick),
    .wd_fire  (wd_fire),
    .sda_lvl  (lines_sync[0]),
    .tick_clr (tick_clr),
    .busy     (busy),
    .done     (done),
    .rx_data  (rx_data),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );
endmodule

// File: rtl/smb_byte_master_chk.sv
module smb_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic scl_oe,
  input logic sda_oe,
  input logic wd_fire
);
  // R1
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R1
  busy_only_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  // R10
  done_on_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R7
  idle_lines_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R9
  timeout_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fire && busy) |=> !busy);
endmodule

bind smb_byte_master smb_byte_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .done     (done),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .wd_fire  (wd_fire)
);

// File: tb/sim_smb_byte_master.sv
module sim_smb_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 4_000_000;
  localparam int TB_SCL_HZ  = 250_000;
  localparam int TB_TO_US   = 100;
  localparam int TB_WD      = (TB_CLK_HZ / 1_000_000) * TB_TO_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, busy, done, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic scl_w, sda_w;

  logic s_drv = 1'b0, s_hold_scl = 1'b0, s_hold_sda = 1'b0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int s_ph = 0, s_bc = 0, s_nack_a = 0, s_nack_d = 0, s_arb_bit = -1;
  int s_starts = 0, s_stops = 0;
  logic [7:0] s_sh = '0, s_got_addr = '0, s_got_data = '0, s_rdbyte = '0;
  logic [6:0] s_addr = '0;
  logic s_mack = 1'b0, s_acked = 1'b0;

  int n_chk = 0, n_err = 0, done_cnt = 0;

  assign scl_w = !(scl_oe || s_hold_scl);
  assign sda_w = !(sda_oe || s_drv || s_hold_sda);

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_byte_master #(.CLK_HZ(TB_CLK_HZ), .SCL_HZ(TB_SCL_HZ), .TIMEOUT_US(TB_TO_US)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .req_wdata(req_wdata), .busy(busy),
    .done(done), .rx_data(rx_data), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl_w), .sda_in(sda_w)
  );

  always @(negedge clk) if (done === 1'b1) done_cnt++;

  // target model
  always @(scl_w or sda_w) begin
    if (scl_w && prev_scl && prev_sda && !sda_w) begin
      s_starts++; s_ph = 1; s_bc = 0; s_sh = '0;
    end else if (scl_w && prev_scl && !prev_sda && sda_w) begin
      s_stops++; s_ph = 0;
    end else if (scl_w && !prev_scl) begin
      if ((s_ph == 1 || s_ph == 2) && s_bc < 8) s_sh = {s_sh[6:0], sda_w};
      if (s_ph == 3 && s_bc == 8) s_mack = sda_w;
      s_bc++;
    end else if (!scl_w && prev_scl) begin
      if (s_ph == 1 || s_ph == 2) begin
        if (s_ph == 1 && s_arb_bit >= 0 && s_bc == s_arb_bit) s_drv = 1'b1;
        if (s_bc == 8) begin
          if (s_ph == 1) begin
            s_got_addr = s_sh;
            s_acked = (s_sh[7:1] == s_addr) && (s_nack_a == 0);
            if (s_nack_a > 0) s_nack_a--;
          end else begin
            s_got_data = s_sh;
            s_acked = (s_nack_d == 0);
            if (s_nack_d > 0) s_nack_d--;
          end
          s_drv = s_acked;
        end else if (s_bc == 9) begin
          s_drv = 1'b0;
          if (s_ph == 1 && s_acked) begin
            s_bc = 0;
            if (s_got_addr[0]) begin s_ph = 3; s_drv = !s_rdbyte[7]; end
            else s_ph = 2;
          end else s_ph = 4;
        end
      end else if (s_ph == 3) begin
        if (s_bc >= 1 && s_bc <= 7) s_drv = !s_rdbyte[7 - s_bc];
        else if (s_bc == 8) s_drv = 1'b0;
        else s_ph = 4;
      end
    end
    prev_scl = scl_w;
    prev_sda = sda_w;
  end

  function automatic logic [7:0] exp_addr_byte(input logic [6:0] a, input bit rd);
    return {a, rd};
  endfunction

  function automatic int exp_starts(input int na, input int nd, input bit rd);
    return 1 + na + (rd ? 0 : nd);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic slave_clear();
    s_ph = 0; s_bc = 0; s_starts = 0; s_stops = 0; s_drv = 1'b0;
    s_got_addr = '0; s_got_data = '0; s_mack = 1'b0; s_arb_bit = -1;
  endtask

  task automatic issue(input logic [6:0] a, input bit rd, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_rd = rd; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R1", busy, 1);
  endtask

  task automatic wait_idle(input int limit, output int cyc);
    cyc = 0;
    while (busy === 1'b1 && cyc < limit) begin @(negedge clk); cyc++; end
  endtask

  task automatic run_txn(input logic [6:0] a, input bit rd, input logic [7:0] wd,
                         input logic [7:0] rb, input int na, input int nd, input bit probe);
    int d0, cyc;
    slave_clear();
    s_addr = a; s_rdbyte = rb; s_nack_a = na; s_nack_d = nd;
    d0 = done_cnt;
    issue(a, rd, wd);
    if (probe) begin
      repeat (40) @(negedge clk);
      chk(req_ready === 1'b0, "R11", req_ready, 0);
      req_valid = 1'b1; req_addr = ~a; req_rd = ~rd; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_idle(20000, cyc);
    chk(done === 1'b1, "R10", done, 1);
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R10", done_cnt - d0, 1);
    chk(s_got_addr == exp_addr_byte(a, rd), probe ? "R11" : "R2",
        s_got_addr, exp_addr_byte(a, rd));
    chk(s_starts == exp_starts(na, nd, rd), (nd > 0) ? "R6" : "R5",
        s_starts, exp_starts(na, nd, rd));
    chk(s_stops == 1, rd ? "R4" : "R3", s_stops, 1);
    if (rd) begin
      chk(rx_data == rb, "R4", rx_data, rb);
      chk(s_mack == 1'b1, "R4", s_mack, 1);
    end else begin
      chk(s_got_data == wd, probe ? "R11" : "R3", s_got_data, wd);
    end
  endtask

  task automatic check_abort(input string rq, input int d0);
    chk(busy === 1'b0, rq, busy, 0);
    chk(done_cnt == d0, rq, done_cnt - d0, 0);
    chk(scl_oe === 1'b0 && sda_oe === 1'b0, rq, {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed_sink, d0, cyc;
    seed_sink = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", {busy, done}, 0);
    chk(req_ready === 1'b1, "R1", req_ready, 1);
    chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R7", {scl_oe, sda_oe}, 0);

    // directed: plain write, plain read, NACK retries
    run_txn(7'h2A, 1'b0, 8'hA5, 8'h00, 0, 0, 1'b0);
    run_txn(7'h51, 1'b1, 8'h00, 8'h3C, 0, 0, 1'b0);
    run_txn(7'h7F, 1'b1, 8'h00, 8'hFF, 2, 0, 1'b0);
    run_txn(7'h00, 1'b0, 8'h00, 8'h00, 1, 2, 1'b0);
    run_txn(7'h13, 1'b0, 8'h81, 8'h00, 0, 0, 1'b1);

    // R7: arbitration loss on an address 1 bit
    slave_clear(); s_addr = 7'h7F; s_arb_bit = 2; d0 = done_cnt;
    issue(7'h7F, 1'b0, 8'h55);
    wait_idle(5000, cyc);
    repeat (100) @(negedge clk);
    check_abort("R7", d0);
    chk(s_starts == 1, "R7", s_starts, 1);
    s_drv = 1'b0; s_arb_bit = -1;
    repeat (10) @(negedge clk);

    // R8: SDA held low before START
    slave_clear(); s_hold_sda = 1'b1; d0 = done_cnt;
    repeat (4) @(negedge clk);
    issue(7'h22, 1'b0, 8'h11);
    wait_idle(200, cyc);
    check_abort("R8", d0);
    chk(cyc < 40, "R8", cyc, 40);
    s_hold_sda = 1'b0;
    repeat (10) @(negedge clk);

    // R12: read right after abort
    run_txn(7'h44, 1'b1, 8'h00, 8'h96, 0, 0, 1'b0);

    // R9: SCL held low by the target
    slave_clear(); d0 = done_cnt;
    @(negedge clk);
    s_hold_scl = 1'b1;
    cyc = 0;
    @(negedge clk); cyc++;
    req_valid = 1'b1; req_addr = 7'h31; req_rd = 1'b1;
    @(negedge clk); cyc++;
    req_valid = 1'b0;
    chk(busy === 1'b1, "R1", busy, 1);
    while (busy === 1'b1 && cyc < TB_WD + 100) begin @(negedge clk); cyc++; end
    check_abort("R9", d0);
    chk(cyc >= TB_WD && cyc <= TB_WD + 8, "R9", cyc, TB_WD);
    s_hold_scl = 1'b0;
    repeat (20) @(negedge clk);

    // R12: read after timeout abort
    run_txn(7'h31, 1'b1, 8'h00, 8'h5A, 1, 0, 1'b0);

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [6:0] a;
      logic [7:0] wd, rb;
      bit rd;
      int na, nd;
      a  = 7'($urandom);
      wd = 8'($urandom);
      rb = 8'($urandom);
      rd = 1'($urandom);
      na = int'($urandom % 3);
      nd = rd ? 0 : int'($urandom % 3);
      run_txn(a, rd, wd, rb, na, nd, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule